// File: doc/BRIEF.md
# Radar Test Pulse Output Selector

This block routes simulated radar pulse trains to three output pins. Its inputs are a high-repetition-rate train, a medium-repetition-rate train and an illumination train, each a single bit from neighbouring logic in the same clock domain. A host drives five active-low control pins through a digital I/O port. One pin is a master pulse enable. The others request the high-rate train, the medium-rate train, the illumination train and a mixed waveform.

Each control pin is slow, asynchronous host wiring. It passes through its own synchronizer chain before any decision uses it. The pulse trains enter the output register directly.

There are three outputs. The rate output carries the chosen repetition-rate train. The illumination output carries the illumination train. The mix output carries the illumination train with the chosen rate pulses ORed on top of it. The pulse trains are continuous waveforms with no framing, so there is no valid/ready handshake and no back-pressure. Every pin is a plain level.

Top module: `radsel_top`

## Requirements
- R1: While `rst_n` is low, `rate_out`, `illum_out` and `mix_out` are 0, and every synchronized control reads as deasserted.
- R2: While the synchronized master enable (`pulse_en_n` low) is deasserted, all three outputs are 0, whatever the other controls and trains do.
- R3: With the master enabled and only the high-rate request asserted (`hrate_req_n` low), `rate_out` equals `hrate_train` delayed by one clock.
- R4: With the master enabled and only the medium-rate request asserted (`mrate_req_n` low), `rate_out` equals `mrate_train` delayed by one clock.
- R5: When both rate requests are asserted, the high-rate train is chosen for `rate_out` and for the mix output. The medium-rate train has no effect.
- R6: With the master enabled and the illumination request asserted (`illum_req_n` low), `illum_out` equals `illum_train` delayed by one clock. Without that request, `illum_out` is 0.
- R7: With the master enabled and the mix request asserted (`mix_req_n` low), `mix_out` equals the one-clock-delayed OR of `illum_train` and the chosen rate train.
- R8: With the mix request asserted and neither rate request asserted, `mix_out` equals `illum_train` delayed by one clock. Without the mix request, `mix_out` is 0.
- R9: A control pin change is seen at the outputs after SYNC_STAGES+1 clock edges: SYNC_STAGES edges through the synchronizer and one edge through the output register. Before that, the outputs still follow the old setting.
- R10: With no rate request asserted, `rate_out` is 0 even when the master is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pulse_en_n | input | 1 | Master pulse enable, active low |
| hrate_req_n | input | 1 | High-rate train request, active low |
| mrate_req_n | input | 1 | Medium-rate train request, active low |
| illum_req_n | input | 1 | Illumination train request, active low |
| mix_req_n | input | 1 | Mixed waveform request, active low |
| hrate_train | input | 1 | High-repetition-rate pulse train |
| mrate_train | input | 1 | Medium-repetition-rate pulse train |
| illum_train | input | 1 | Illumination pulse train |
| rate_out | output | 1 | Chosen repetition-rate train, registered |
| illum_out | output | 1 | Illumination train, registered |
| mix_out | output | 1 | Illumination train with rate pulses ORed on, registered |

## Verification
The bench builds the block with its default SYNC_STAGES of 2. A control change therefore reaches the outputs on the third edge, and the bench can check the exact latency of R9, including the two edges on which the old setting still shows. For each control setting, the bench drives all eight combinations of the three trains plus a longer irregular pattern. This covers both sides of the high-over-medium priority and the mix output with and without a rate train behind it.

// File: rtl/radsel_pkg.sv
package radsel_pkg;
  localparam int CTRL_W = 5;

  // active-high view of the host controls after synchronization
  typedef struct packed {
    logic master;
    logic hrate;
    logic mrate;
    logic illum;
    logic mix;
  } ctrl_t;

  // decoded routing decisions
  typedef struct packed {
    logic pick_h;
    logic pick_m;
    logic illum;
    logic mix;
  } route_t;
endpackage

// File: rtl/radsel_sync.sv
module radsel_sync #(
  parameter int WIDTH     = 5,
  parameter int STAGES    = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  localparam int LAST = STAGES - 1;

  logic [WIDTH-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[0] <= RST_VAL;
          else        chain[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[s] <= RST_VAL;
          else        chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign q = chain[LAST];
endmodule

// File: rtl/radsel_decode.sv
module radsel_decode
  import radsel_pkg::*;
(
  input  ctrl_t  ctrl,
  output route_t route
);
  always_comb begin
    route        = '0;
    if (ctrl.master) begin
      route.pick_h = ctrl.hrate;
      route.pick_m = ctrl.mrate & ~ctrl.hrate;
      route.illum  = ctrl.illum;
      route.mix    = ctrl.mix;
    end
  end
endmodule

// File: rtl/radsel_outreg.sv
module radsel_outreg
  import radsel_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  route_t route,
  input  logic   hrate_train,
  input  logic   mrate_train,
  input  logic   illum_train,
  output logic   rate_out,
  output logic   illum_out,
  output logic   mix_out
);
  logic rate_pick;

  always_comb begin
    rate_pick = (route.pick_h & hrate_train) | (route.pick_m & mrate_train);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rate_out  <= 1'b0;
      illum_out <= 1'b0;
      mix_out   <= 1'b0;
    end else begin
      rate_out  <= rate_pick;
      illum_out <= route.illum & illum_train;
      mix_out   <= route.mix & (illum_train | rate_pick);
    end
  end

  p_quiet_when_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(route) == '0) |-> (!rate_out && !illum_out && !mix_out));

  p_mix_covers_illum_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(route.mix && illum_train) |-> mix_out);

  p_high_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(route.pick_h) |-> (rate_out == $past(hrate_train)));

  p_illum_follow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(route.illum) |-> (illum_out == $past(illum_train)));
endmodule

// File: rtl/radsel_top.sv
module radsel_top
  import radsel_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pulse_en_n,
  input  logic hrate_req_n,
  input  logic mrate_req_n,
  input  logic illum_req_n,
  input  logic mix_req_n,
  input  logic hrate_train,
  input  logic mrate_train,
  input  logic illum_train,
  output logic rate_out,
  output logic illum_out,
  output logic mix_out
);
  logic [CTRL_W-1:0] raw_n;
  logic [CTRL_W-1:0] sync_n;
  ctrl_t             ctrl;
  route_t            route;

  assign raw_n = {pulse_en_n, hrate_req_n, mrate_req_n, illum_req_n, mix_req_n};

  radsel_sync #(
    .WIDTH  (CTRL_W),
    .STAGES (SYNC_STAGES),
    .RST_VAL({CTRL_W{1'b1}})
  ) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (raw_n),
    .q    (sync_n)
  );

  assign ctrl = ctrl_t'(~sync_n);

  radsel_decode u_dec (
    .ctrl (ctrl),
    .route(route)
  );

  radsel_outreg u_out (
    .clk        (clk),
    .rst_n      (rst_n),
    .route      (route),
    .hrate_train(hrate_train),
    .mrate_train(mrate_train),
    .illum_train(illum_train),
    .rate_out   (rate_out),
    .illum_out  (illum_out),
    .mix_out    (mix_out)
  );

  p_single_rate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({route.pick_h, route.pick_m}));

  p_master_gates_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl.master |-> (route == '0));

  p_rate_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!ctrl.hrate && !ctrl.mrate) |-> !rate_out);
endmodule

// File: tb/radsel_top_test.sv
module radsel_top_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pulse_en_n = 1'b1, hrate_req_n = 1'b1, mrate_req_n = 1'b1;
  logic illum_req_n = 1'b1, mix_req_n = 1'b1;
  logic hrate_train = 1'b0, mrate_train = 1'b0, illum_train = 1'b0;
  logic rate_out, illum_out, mix_out;

  int compared = 0;
  int mismatched = 0;
  int cyc = 0;
  bit done = 1'b0;

  // bench copy of the control setting (active high)
  bit m_en, m_h, m_m, m_i, m_x;

  typedef struct {
    int       due;
    logic [2:0] exp;
    string    tag;
  } item_t;
  item_t sbq[$];

  always #2 clk = ~clk;  // 250 MHz
  always @(posedge clk) cyc <= cyc + 1;

  radsel_top uut (
    .clk(clk), .rst_n(rst_n),
    .pulse_en_n(pulse_en_n), .hrate_req_n(hrate_req_n), .mrate_req_n(mrate_req_n),
    .illum_req_n(illum_req_n), .mix_req_n(mix_req_n),
    .hrate_train(hrate_train), .mrate_train(mrate_train), .illum_train(illum_train),
    .rate_out(rate_out), .illum_out(illum_out), .mix_out(mix_out)
  );

  function automatic logic [2:0] model(bit h, bit m, bit i);
    bit pick;
    pick = m_h ? h : (m_m ? m : 1'b0);
    return {m_en & pick, m_en & m_i & i, m_en & m_x & (i | pick)};
  endfunction

  task automatic check(string tag, logic [2:0] act, logic [2:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: {rate,illum,mix} actual %b expected %b", tag, act, exp);
    end
  endtask

  // monitor: pops items whose due cycle has come
  initial begin
    forever begin
      @(negedge clk);
      while (sbq.size() > 0 && sbq[0].due == cyc) begin
        item_t it;
        it = sbq.pop_front();
        check(it.tag, {rate_out, illum_out, mix_out}, it.exp);
      end
    end
  end

  task automatic set_ctrl(bit en, bit h, bit m, bit i, bit x);
    @(negedge clk);
    {pulse_en_n, hrate_req_n, mrate_req_n, illum_req_n, mix_req_n} = ~{en, h, m, i, x};
    m_en = en; m_h = h; m_m = m; m_i = i; m_x = x;
    repeat (4) @(negedge clk);
  endtask

  task automatic drive(bit h, bit m, bit i, string tag);
    item_t it;
    @(negedge clk);
    hrate_train = h; mrate_train = m; illum_train = i;
    it.due = cyc + 1;
    it.exp = model(h, m, i);
    it.tag = tag;
    sbq.push_back(it);
  endtask

  task automatic sweep(string tag);
    for (int k = 0; k < 8; k++) drive(k[2], k[1], k[0], tag);
    for (int k = 0; k < 16; k++) drive(k[0] ^ k[3], k[1] ^ k[2], k[2] | k[0], tag);
  endtask

  initial begin
    fork
      begin
        #100000;
        if (!done) begin
          mismatched++;
          $display("FAIL watchdog: actual hung expected finish");
        end
      end
      begin
        repeat (3) @(negedge clk);
        hrate_train = 1; mrate_train = 1; illum_train = 1;
        {pulse_en_n, hrate_req_n, mrate_req_n, illum_req_n, mix_req_n} = '0;
        @(negedge clk);
        check("R1 reset", {rate_out, illum_out, mix_out}, 3'b000);
        {pulse_en_n, hrate_req_n, mrate_req_n, illum_req_n, mix_req_n} = '1;
        rst_n = 1'b1;
        // R1: controls read deasserted right after reset, so outputs stay low
        @(negedge clk);
        check("R1 post-reset", {rate_out, illum_out, mix_out}, 3'b000);

        set_ctrl(0, 1, 1, 1, 1); sweep("R2 master off");
        set_ctrl(1, 1, 0, 0, 0); sweep("R3 high only");
        set_ctrl(1, 0, 1, 0, 0); sweep("R4 medium only");
        set_ctrl(1, 1, 1, 0, 1); sweep("R5 both rates");
        set_ctrl(1, 0, 0, 1, 0); sweep("R6 illum only");
        set_ctrl(1, 0, 1, 0, 1); sweep("R7 mix medium");
        set_ctrl(1, 1, 0, 1, 1); sweep("R7 mix high");
        set_ctrl(1, 0, 0, 1, 1); sweep("R8 mix no rate");
        set_ctrl(1, 0, 0, 0, 0); sweep("R10 no rate");

        // R9: latency of a control change with trains held high
        @(negedge clk);
        hrate_train = 1; mrate_train = 1; illum_train = 1;
        @(negedge clk);
        check("R9 before change", {rate_out, illum_out, mix_out}, 3'b000);
        {pulse_en_n, hrate_req_n, illum_req_n} = 3'b000;
        @(negedge clk);
        check("R9 edge 1", {rate_out, illum_out, mix_out}, 3'b000);
        @(negedge clk);
        check("R9 edge 2", {rate_out, illum_out, mix_out}, 3'b000);
        @(negedge clk);
        check("R9 edge 3", {rate_out, illum_out, mix_out}, 3'b110);
        pulse_en_n = 1'b1;
        @(negedge clk);
        check("R9 off edge 1", {rate_out, illum_out, mix_out}, 3'b110);
        @(negedge clk);
        check("R9 off edge 2", {rate_out, illum_out, mix_out}, 3'b110);
        @(negedge clk);
        check("R9 off edge 3 R2", {rate_out, illum_out, mix_out}, 3'b000);
        repeat (3) @(negedge clk);
        if (sbq.size() != 0) begin
          mismatched++;
          $display("FAIL scoreboard: actual %0d pending expected 0", sbq.size());
        end
        done = 1'b1;
      end
    join_any
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule